// File: doc/BRIEF.md
# Per-Port Statistics Counter Bank

This block keeps the traffic statistics of a multi-port switch. Each port owns 33 event counters, 3 of them 64 bits wide (byte totals) and the rest 32 bits wide (frame and error tallies). Upstream logic raises one increment strobe per counter per cycle. The byte counters add a per-port length value; every other counter adds one.

Software sees the counters through a 16-bit register bus. A wide counter cannot be read atomically 16 bits at a time. So a write to a counter's base address copies that counter into a 64-bit snapshot, and the following reads return the snapshot one word at a time. A control register reports whether a snapshot is still being taken and whether a clear sweep is running. It also accepts a clear command for the whole bank or for any set of ports.

Top module: `stat_counter_bank`

## Requirements
- R1: After reset, every counter, the snapshot and `rdata_o` are zero, and the control register reads 0.
- R2: Counter k of port p has its base word at 0x1000 + 0x40*p + off(k) for k < 29, and at 0x1180 + 8*p + off(k) for k in 29..32. For k < 29, off(k) is:
  - 0 for k=0 and 4 for k=1;
  - 8 + 2*(k-2) for k in 2..19;
  - 44 for k=20;
  - 48 + 2*(k-21) for k in 21..28.
  For k in 29..32, off(k) = 2*(k-29).
  Counters 0, 1 and 20 are wide (four words). All others are narrow (two words).
- R3: Strobe bit `inc_i[p*33+k]` advances counter k of port p when sampled high. Counters 0 and 1 add `rx_len_i[p*16 +: 16]`, counter 20 adds `tx_len_i[p*16 +: 16]`, and all others add 1. With no strobe and no clear, a counter holds its value.
- R4: Narrow counters wrap modulo 2^NARROW_W and wide counters wrap modulo 2^WIDE_W (defaults 32 and 64). They never saturate.
- R5: A bus write of any data to a counter's base address starts a snapshot of that counter. Once it completes, a read of base+i (i in 0..3) returns bits 16*i+15..16*i, with word 0 least significant. Words above the counter's width read 0. Reads anywhere else in the counter regions return 0.
- R6: After a snapshot completes, further increments do not change the words read back until the next snapshot trigger.
- R7: Writes to counter-region addresses that are not a base address are ignored: busy stays 0 and the snapshot and its address are unchanged.
- R8: Control bit 0 (busy) reads 1 for exactly BUSY_CYC consecutive cycles starting with the cycle after the trigger write, then 0. The snapshot holds the counter value at the cycle busy falls.
- R9: Writing control bit 2 clears every counter of every port. Control bit 1 (clearing) reads 1 for NUM_PORTS cycles starting with the cycle after the write, then 0.
- R10: Writing control bit 3+p clears only the counters of port p; other ports keep their values. Ports are swept one per cycle, lowest first.
- R11: An increment sampled in the same cycle as the clear of its counter is lost, and the counter reads 0 afterwards.
- R12: Control register reads (0x11F0) return 0 in bits 15..2. Reads of addresses outside the counter regions and the control register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | ADDR_W | Bus word address |
| wdata_i | input | DATA_W | Bus write data |
| rdata_o | output | DATA_W | Bus read data, valid the cycle after `rd_en_i` |
| inc_i | input | NUM_PORTS*33 | Increment strobe per port and counter |
| rx_len_i | input | NUM_PORTS*LEN_W | Per-port receive byte count for counters 0 and 1 |
| tx_len_i | input | NUM_PORTS*LEN_W | Per-port transmit byte count for counter 20 |

## Verification
A wrong counter or a misdecoded base address shows up at `rdata_o` as a wrong word after the next snapshot, a few cycles after the trigger write. A wrong busy length or sweep length shows up on the very next control-register reads, since the bench polls them cycle by cycle. A clear that races an increment, or that spills onto a neighbouring port, is exposed when the affected counters are snapshotted right after the sweep. A wrap fault appears once a reduced-width instance is driven past its modulus.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int NUM_PRI = 29;
  localparam int NUM_SEC = 4;
  localparam int NUM_CNT = NUM_PRI + NUM_SEC;
  localparam int SNAP_W  = 64;

  typedef enum logic [1:0] {SRC_ONE, SRC_RX, SRC_TX} src_e;

  // word offset of counter k inside its region
  function automatic int word_off(int k);
    if (k == 0) return 0;
    if (k == 1) return 4;
    if (k < 20) return 8 + 2 * (k - 2);
    if (k == 20) return 44;
    if (k < NUM_PRI) return 48 + 2 * (k - 21);
    return 2 * (k - NUM_PRI);
  endfunction

  function automatic bit is_wide(int k);
    return (k == 0) || (k == 1) || (k == 20);
  endfunction

  function automatic src_e amt_src(int k);
    if (k == 0 || k == 1) return SRC_RX;
    if (k == 20) return SRC_TX;
    return SRC_ONE;
  endfunction
endpackage

// File: rtl/stat_addr_decode.sv
module stat_addr_decode #(
  parameter int ADDR_W = 16,
  parameter int NUM_PORTS = 6,
  parameter int PORT_W = 3,
  parameter int CNT_W = 6,
  parameter logic [ADDR_W-1:0] PRI_BASE = 16'h1000,
  parameter int PRI_STRIDE = 64,
  parameter logic [ADDR_W-1:0] SEC_BASE = 16'h1180,
  parameter int SEC_STRIDE = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h11F0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_cnt_o,
  output logic              is_base_o,
  output logic              is_ctrl_o,
  output logic [PORT_W-1:0] port_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int PRI_SH = $clog2(PRI_STRIDE);
  localparam int SEC_SH = $clog2(SEC_STRIDE);
  localparam logic [ADDR_W-1:0] PRI_SPAN = ADDR_W'(NUM_PORTS * PRI_STRIDE);
  localparam logic [ADDR_W-1:0] SEC_SPAN = ADDR_W'(NUM_PORTS * SEC_STRIDE);

  logic [ADDR_W-1:0] pri_rel, sec_rel;
  logic in_pri, in_sec;

  assign pri_rel   = addr_i - PRI_BASE;
  assign sec_rel   = addr_i - SEC_BASE;
  assign in_pri    = (addr_i >= PRI_BASE) && (pri_rel < PRI_SPAN);
  assign in_sec    = (addr_i >= SEC_BASE) && (sec_rel < SEC_SPAN);
  assign in_cnt_o  = in_pri || in_sec;
  assign is_ctrl_o = (addr_i == CTRL_ADDR);

  always_comb begin
    is_base_o = 1'b0;
    port_o    = '0;
    cnt_o     = '0;
    if (in_pri) begin
      port_o = PORT_W'(pri_rel >> PRI_SH);
      for (int k = 0; k < stat_pkg::NUM_PRI; k++)
        if (pri_rel[PRI_SH-1:0] == PRI_SH'(stat_pkg::word_off(k))) begin
          is_base_o = 1'b1;
          cnt_o     = CNT_W'(k);
        end
    end else if (in_sec) begin
      port_o = PORT_W'(sec_rel >> SEC_SH);
      for (int k = stat_pkg::NUM_PRI; k < stat_pkg::NUM_CNT; k++)
        if (sec_rel[SEC_SH-1:0] == SEC_SH'(stat_pkg::word_off(k))) begin
          is_base_o = 1'b1;
          cnt_o     = CNT_W'(k);
        end
    end
  end
endmodule

// File: rtl/stat_ctr.sv
module stat_ctr #(
  parameter int W = 32,
  parameter int AMT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [63:0]      val_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] amt_ext;

  assign amt_ext = W'(amt_i);
  assign val_o   = 64'(cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;           // clear beats increment
    else if (inc_i)   cnt_q <= cnt_q + amt_ext; // modulo 2^W

  assert_clear_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  assert_hold_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_q));
endmodule

// File: rtl/stat_snap.sv
module stat_snap #(
  parameter int ADDR_W = 16,
  parameter int PORT_W = 3,
  parameter int CNT_W = 6,
  parameter int BUSY_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [PORT_W-1:0] trig_port_i,
  input  logic [CNT_W-1:0]  trig_cnt_i,
  input  logic [ADDR_W-1:0] trig_addr_i,
  output logic [PORT_W-1:0] sel_port_o,
  output logic [CNT_W-1:0]  sel_cnt_o,
  input  logic [63:0]       sel_val_i,
  output logic              busy_o,
  output logic [63:0]       snap_o,
  output logic [ADDR_W-1:0] base_o
);
  localparam int BUSY_W = $clog2(BUSY_CYC + 1);

  logic [BUSY_W-1:0] busy_cnt_q;

  assign busy_o = (busy_cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      busy_cnt_q <= '0;
      sel_port_o <= '0;
      sel_cnt_o  <= '0;
      base_o     <= '0;
      snap_o     <= '0;
    end else if (trig_i) begin
      busy_cnt_q <= BUSY_W'(BUSY_CYC);
      sel_port_o <= trig_port_i;
      sel_cnt_o  <= trig_cnt_i;
      base_o     <= trig_addr_i;
    end else if (busy_o) begin
      busy_cnt_q <= busy_cnt_q - 1'b1;
      if (busy_cnt_q == BUSY_W'(1)) snap_o <= sel_val_i;
    end

  assert_trig_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> busy_o);
  assert_snap_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_i && !busy_o) |=> $stable(snap_o));
  assert_base_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_i |=> $stable(base_o));
endmodule

// File: rtl/stat_clr.sv
module stat_clr #(
  parameter int NUM_PORTS = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [NUM_PORTS-1:0] mask_i,
  output logic [NUM_PORTS-1:0] port_clr_o,
  output logic                 active_o
);
  logic [NUM_PORTS-1:0] pend_q;
  logic found;

  assign active_o = |pend_q;

  // one port per cycle, lowest index first
  always_comb begin
    port_clr_o = '0;
    found      = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (pend_q[p] && !found) begin
        port_clr_o[p] = 1'b1;
        found         = 1'b1;
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~port_clr_o) | (req_i ? mask_i : '0);

  assert_one_port_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(port_clr_o));
  assert_sweep_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (mask_i != '0)) |=> active_o);
  assert_sweep_moves_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (port_clr_o != '0));
endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank #(
  parameter int NUM_PORTS = 6,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LEN_W = 16,
  parameter int NARROW_W = 32,
  parameter int WIDE_W = 64,
  parameter int BUSY_CYC = 3,
  parameter logic [ADDR_W-1:0] PRI_BASE = 16'h1000,
  parameter int PRI_STRIDE = 64,
  parameter logic [ADDR_W-1:0] SEC_BASE = 16'h1180,
  parameter int SEC_STRIDE = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h11F0
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   wr_en_i,
  input  logic                                   rd_en_i,
  input  logic [ADDR_W-1:0]                      addr_i,
  input  logic [DATA_W-1:0]                      wdata_i,
  output logic [DATA_W-1:0]                      rdata_o,
  input  logic [NUM_PORTS*stat_pkg::NUM_CNT-1:0] inc_i,
  input  logic [NUM_PORTS*LEN_W-1:0]             rx_len_i,
  input  logic [NUM_PORTS*LEN_W-1:0]             tx_len_i
);
  localparam int NUM_CNT = stat_pkg::NUM_CNT;
  localparam int PORT_W  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int CNT_W   = $clog2(NUM_CNT);
  localparam int WORDS   = stat_pkg::SNAP_W / DATA_W;
  localparam int GLB_BIT = 2;
  localparam int PRT_BIT = 3;

  logic in_cnt, is_base, is_ctrl;
  logic [PORT_W-1:0] dec_port, sel_port;
  logic [CNT_W-1:0]  dec_cnt, sel_cnt;
  logic [63:0] cnt_val [NUM_PORTS][NUM_CNT];
  logic [63:0] sel_val, snap;
  logic [ADDR_W-1:0] snap_base, rd_rel;
  logic [DATA_W-1:0] snap_word [WORDS];
  logic [NUM_PORTS-1:0] clr_mask, port_clr;
  logic busy, clearing, trig, ctrl_wr;
  logic unused_wdata;

  stat_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .CNT_W(CNT_W),
    .PRI_BASE(PRI_BASE), .PRI_STRIDE(PRI_STRIDE), .SEC_BASE(SEC_BASE),
    .SEC_STRIDE(SEC_STRIDE), .CTRL_ADDR(CTRL_ADDR)
  ) u_dec (
    .addr_i(addr_i), .in_cnt_o(in_cnt), .is_base_o(is_base),
    .is_ctrl_o(is_ctrl), .port_o(dec_port), .cnt_o(dec_cnt)
  );

  assign trig    = wr_en_i && is_base;
  assign ctrl_wr = wr_en_i && is_ctrl;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_mask
    assign clr_mask[p] = wdata_i[GLB_BIT] | wdata_i[PRT_BIT+p];
  end
  assign unused_wdata = ^{wdata_i[1:0], wdata_i[DATA_W-1:PRT_BIT+NUM_PORTS]};

  stat_clr #(.NUM_PORTS(NUM_PORTS)) u_clr (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(ctrl_wr), .mask_i(clr_mask),
    .port_clr_o(port_clr), .active_o(clearing)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
      localparam int W = stat_pkg::is_wide(k) ? WIDE_W : NARROW_W;
      localparam stat_pkg::src_e SRC = stat_pkg::amt_src(k);
      logic [LEN_W-1:0] amt;
      if (SRC == stat_pkg::SRC_RX) begin : g_rx
        assign amt = rx_len_i[p*LEN_W +: LEN_W];
      end else if (SRC == stat_pkg::SRC_TX) begin : g_tx
        assign amt = tx_len_i[p*LEN_W +: LEN_W];
      end else begin : g_one
        assign amt = LEN_W'(1);
      end
      stat_ctr #(.W(W), .AMT_W(LEN_W)) u_ctr (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(port_clr[p]),
        .inc_i(inc_i[p*NUM_CNT+k]), .amt_i(amt), .val_o(cnt_val[p][k])
      );
    end
  end

  assign sel_val = cnt_val[sel_port][sel_cnt];

  stat_snap #(
    .ADDR_W(ADDR_W), .PORT_W(PORT_W), .CNT_W(CNT_W), .BUSY_CYC(BUSY_CYC)
  ) u_snap (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig), .trig_port_i(dec_port),
    .trig_cnt_i(dec_cnt), .trig_addr_i(addr_i), .sel_port_o(sel_port),
    .sel_cnt_o(sel_cnt), .sel_val_i(sel_val), .busy_o(busy),
    .snap_o(snap), .base_o(snap_base)
  );

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign snap_word[w] = snap[w*DATA_W +: DATA_W];
  end

  assign rd_rel = addr_i - snap_base;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rdata_o <= '0;
    else if (rd_en_i) begin
      if (is_ctrl)
        rdata_o <= DATA_W'({clearing, busy});
      else if (in_cnt && rd_rel < ADDR_W'(WORDS))
        rdata_o <= snap_word[rd_rel[$clog2(WORDS)-1:0]];
      else
        rdata_o <= '0;
    end

  assert_ctrl_layout_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && is_ctrl) |=> (rdata_o[DATA_W-1:2] == '0));
  assert_unmapped_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !is_ctrl && !in_cnt) |=> (rdata_o == '0));
  assert_ctrl_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && is_ctrl && busy) |=> rdata_o[0]);
endmodule

// File: tb/tb_stat_counter_bank.sv
module tb_stat_counter_bank;
  localparam int NP = 6;
  localparam int NC = 33;
  localparam int NW = 12;
  localparam int WW = 20;
  localparam int BC = 3;
  localparam logic [15:0] CTRL = 16'h11F0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic [15:0] rdata;
  logic [NP*NC-1:0] inc = '0;
  logic [NP*16-1:0] rx_len = '0, tx_len = '0;

  int total = 0, bad = 0;
  longint unsigned exp_v [NP][NC];

  always #4 clk = ~clk;

  stat_counter_bank #(.NARROW_W(NW), .WIDE_W(WW), .BUSY_CYC(BC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .inc_i(inc),
    .rx_len_i(rx_len), .tx_len_i(tx_len)
  );

  task automatic chk(string req, longint unsigned act, longint unsigned exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int off_of(int k);
    if (k == 0) return 0;
    if (k == 1) return 4;
    if (k <= 19) return 8 + 2 * (k - 2);
    if (k == 20) return 44;
    if (k <= 28) return 48 + 2 * (k - 21);
    return 2 * (k - 29);
  endfunction

  function automatic logic [15:0] base_of(int p, int k);
    if (k < 29) return 16'(16'h1000 + 16'h40 * p + off_of(k));
    return 16'(16'h1180 + 8 * p + off_of(k));
  endfunction

  function automatic longint unsigned wmask(int k);
    int w = (k == 0 || k == 1 || k == 20) ? WW : NW;
    return (64'd1 << w) - 1;
  endfunction

  // all tasks start and end right after a negedge
  task automatic bus_write(logic [15:0] a, logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [15:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic read_words(logic [15:0] a, output longint unsigned v);
    logic [15:0] d;
    v = 0;
    for (int i = 0; i < 4; i++) begin
      bus_read(16'(a + i), d);
      v = v | (longint'(d) << (16 * i));
    end
  endtask

  task automatic snap_read(int p, int k, output longint unsigned v);
    logic [15:0] d;
    bus_write(base_of(p, k), 16'hA5A5);
    for (int i = 0; i < 20; i++) begin
      bus_read(CTRL, d);
      if (!d[0]) break;
    end
    read_words(base_of(p, k), v);
  endtask

  task automatic do_inc(int p, int k, int n, logic [15:0] len);
    longint unsigned amt = (k == 0 || k == 1 || k == 20) ? longint'(len) : 1;
    for (int i = 0; i < n; i++) begin
      inc[p*NC+k] = 1'b1;
      rx_len[p*16 +: 16] = len;
      tx_len[p*16 +: 16] = len;
      @(negedge clk);
    end
    inc = '0;
    exp_v[p][k] = (exp_v[p][k] + longint'(n) * amt) & wmask(k);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    longint unsigned v;
    chk("R1 rdata after reset", rdata, 0);
    bus_read(CTRL, d);
    chk("R1 control after reset", d, 0);
    snap_read(4, 20, v);
    chk("R1 counter zero after reset", v, 0);
  endtask

  task automatic t_basic();
    longint unsigned v;
    do_inc(2, 5, 7, 0);
    do_inc(5, 31, 3, 0);
    do_inc(1, 1, 3, 16'h1234);
    do_inc(3, 20, 2, 16'h00FF);
    do_inc(0, 28, 4, 0);
    do_inc(4, 32, 1, 0);
    snap_read(2, 5, v);  chk("R2 R3 port2 cnt5", v, exp_v[2][5]);
    snap_read(5, 31, v); chk("R2 R3 port5 secondary cnt31", v, exp_v[5][31]);
    snap_read(1, 1, v);  chk("R3 port1 rx octets", v, exp_v[1][1]);
    snap_read(3, 20, v); chk("R3 port3 tx octets", v, exp_v[3][20]);
    snap_read(0, 28, v); chk("R2 port0 last primary", v, exp_v[0][28]);
    snap_read(4, 32, v); chk("R2 port4 last secondary", v, exp_v[4][32]);
    snap_read(2, 6, v);  chk("R3 neighbour untouched", v, 0);
  endtask

  task automatic t_busy();
    logic [15:0] d;
    longint unsigned v;
    do_inc(3, 7, 5, 0);
    bus_write(base_of(3, 7), 16'h0);
    for (int i = 0; i < BC + 1; i++) begin
      bus_read(CTRL, d);
      chk("R8 busy window", d[0], (i < BC) ? 1 : 0);
    end
    read_words(base_of(3, 7), v);
    chk("R8 snapshot after busy", v, exp_v[3][7]);
  endtask

  task automatic t_words();
    logic [15:0] d;
    longint unsigned v;
    do_inc(0, 1, 16, 16'hFFFF);  // 0xFFFF0 in 20 bits
    snap_read(0, 1, v);
    chk("R5 wide word assembly", v, exp_v[0][1]);
    bus_read(16'(base_of(0, 1) + 1), d);
    chk("R5 word1 of wide", d, 16'(exp_v[0][1] >> 16));
    bus_read(16'(base_of(0, 1) + 4), d);
    chk("R5 outside snapshot window", d, 0);
  endtask

  task automatic t_coherent();
    longint unsigned v, old;
    do_inc(5, 9, 2, 0);
    snap_read(5, 9, old);
    do_inc(5, 9, 5, 0);
    read_words(base_of(5, 9), v);
    chk("R6 snapshot held", v, old);
    snap_read(5, 9, v);
    chk("R6 fresh snapshot", v, exp_v[5][9]);
  endtask

  task automatic t_ignored();
    logic [15:0] d;
    longint unsigned v, old;
    snap_read(3, 20, old);
    do_inc(3, 20, 1, 16'h0011);
    bus_write(16'(base_of(3, 20) + 1), 16'hFFFF);
    bus_read(CTRL, d);
    chk("R7 odd word write no busy", d[0], 0);
    bus_write(16'(base_of(3, 20) + 2), 16'hFFFF);
    bus_read(CTRL, d);
    chk("R7 mid word write no busy", d[0], 0);
    read_words(base_of(3, 20), v);
    chk("R7 snapshot unchanged", v, old);
  endtask

  task automatic t_wrap();
    longint unsigned v;
    do_inc(0, 2, 4097, 0);
    snap_read(0, 2, v);
    chk("R4 narrow wrap", v, 1);
    do_inc(4, 0, 17, 16'hFFFF);
    snap_read(4, 0, v);
    chk("R4 wide wrap", v, exp_v[4][0]);
  endtask

  task automatic t_port_clear();
    logic [15:0] d;
    longint unsigned v;
    do_inc(1, 3, 4, 0);
    do_inc(1, 30, 2, 0);
    do_inc(2, 3, 2, 0);
    bus_write(CTRL, 16'(1 << (3 + 1)));
    // port 1 is cleared at the next edge; race increments into it
    inc[1*NC+3] = 1'b1;
    inc[2*NC+3] = 1'b1;
    @(negedge clk);
    inc = '0;
    for (int k = 0; k < NC; k++) exp_v[1][k] = 0;
    exp_v[2][3] = exp_v[2][3] + 1;
    bus_read(CTRL, d);
    chk("R10 single-port sweep done", d[1], 0);
    snap_read(1, 3, v);  chk("R11 racing increment lost", v, 0);
    snap_read(1, 30, v); chk("R10 port1 secondary cleared", v, 0);
    snap_read(2, 3, v);  chk("R10 port2 kept", v, exp_v[2][3]);
    snap_read(2, 5, v);  chk("R10 port2 other kept", v, exp_v[2][5]);
  endtask

  task automatic t_global_clear();
    logic [15:0] d;
    longint unsigned v;
    bus_write(CTRL, 16'h0004);
    for (int i = 0; i < NP + 1; i++) begin
      bus_read(CTRL, d);
      chk("R9 clearing window", d[1], (i < NP) ? 1 : 0);
    end
    for (int p = 0; p < NP; p++)
      for (int k = 0; k < NC; k++) exp_v[p][k] = 0;
    snap_read(2, 3, v);  chk("R9 port2 cleared", v, 0);
    snap_read(5, 31, v); chk("R9 port5 cleared", v, 0);
    snap_read(4, 0, v);  chk("R9 port4 wide cleared", v, 0);
  endtask

  task automatic t_map_misc();
    logic [15:0] d;
    bus_read(16'h2000, d);
    chk("R12 unmapped read", d, 0);
    bus_read(CTRL, d);
    chk("R12 idle control", d, 0);
    bus_read(16'h11B0, d);
    chk("R12 gap above secondary", d, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++)
      for (int k = 0; k < NC; k++) exp_v[p][k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_busy();
    t_words();
    t_coherent();
    t_ignored();
    t_wrap();
    t_port_clear();
    t_global_clear();
    t_map_misc();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule